// File: doc/BRIEF.md
# Coarse-fine 14-bit PWM generator

This block turns a 14-bit setting into one high-resolution pulse-width-modulated output. The output is meant to be smoothed by an external RC filter into an analog control level. A free-running 14-bit counter advances once per tick. The counter splits into a 7-bit position inside a subperiod and a 7-bit subperiod index, so one frame holds 128 subperiods of 128 ticks each.

The upper half of the setting gives a coarse pulse that repeats in every subperiod. The lower half adds single-tick fine pulses to a chosen set of subperiods. The fine pulses are spread evenly over the frame, so the filtered level carries little ripple. The two pulse sources are OR-combined.

A narrow register-write port loads the two 7-bit halves and a control word. The control word holds the enable, the polarity and a static level. The generator takes up a new setting only at a subperiod boundary.

Top module: `cfpwm14`

## Requirements
- R1: While reset is held and after it is released, `pwm_o` is 0, both setting halves are 0 and the control word is cleared (enable 0, invert 0, level 0). Reset asserts asynchronously. Internally it is released on the second rising clock edge after `rst_n` goes high, and registers change from the third edge on.
- R2: The 14-bit counter advances once every 3 clock cycles. A subperiod lasts 384 cycles and a frame lasts 49152 cycles. The counter wraps from 16383 to 0.
- R3: With high half H and no fine pulses, the output is low for the first H+1 ticks of each subperiod and high for the remaining 127−H ticks. That is 3·(127−H) high cycles in every 384-cycle window, and H=127 gives no coarse pulse.
- R4: Let k be the number of trailing zeros of a nonzero subperiod index s. If bit k of the low half is 0, a fine pulse of exactly one tick drives the output high at position 0 of subperiod s. Clearing bit k therefore selects 2^(6−k) subperiods. Subperiod 0 never gets a fine pulse, and the selections of several zero bits combine.
- R5: The coarse and fine pulses are OR-combined. Over a frame the output is high for 3·(128·(127−H) + F) cycles, where F is the number of selected subperiods.
- R6: A write with `wr_sel`=0 replaces the low half, and a write with `wr_sel`=1 replaces the high half; each write keeps the other half. The generator copies the setting only when a subperiod ends, so the subperiod in progress finishes with the old setting.
- R7: Control bit 1 (invert) set to 1 inverts the combined pulse at the output.
- R8: A write with `wr_sel`=2 loads the control word: bit 0 enable, bit 1 invert, bit 2 level. With enable 0, `pwm_o` equals the level bit. Writes with `wr_sel`=3 change nothing.
- R9: Asserting reset in the middle of operation returns the block to the R1 state. After release, the output stays at 0 until the control word is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 low half, 1 high half, 2 control, 3 none |
| wr_data | input | 7 | Write data |
| pwm_o | output | 1 | PWM output, or the static level when disabled |

## Verification
The assertions assume that `wr_en` is sampled only on rising edges. They also assume the tick divider is at least 2, so that a tick never lasts two cycles in a row. A write may arrive in any cycle, including the last tick of a subperiod. The stimulus drives every input on falling edges and keeps each write strobe to one cycle. It covers writes to all four select values, including the ignored one. It places a high-half update in the middle of a subperiod, so the rule that a new setting waits for the subperiod boundary is exercised against the reference model.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    logic en;
    logic inv;
    logic lvl;
  } ctrl_t;
endpackage

// File: rtl/cfp_rstsync.sv
module cfp_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;
  logic [1:0] sr_d;

  always_comb sr_d = {sr_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/cfp_tick.sv
module cfp_tick #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic [DW-1:0] div_d;

  always_comb begin
    tick  = (div_q == DW'(DIV - 1));
    div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  generate
    if (DIV > 1) begin : g_chk
      // R2: a tick is a single-cycle enable
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/cfp_regs.sv
module cfp_regs
  import cfp_pkg::*;
#(
  parameter int HALF_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [HALF_W-1:0]     wr_data,
  output logic [2*HALF_W-1:0]   work,
  output ctrl_t                 ctrl
);
  localparam int SW = 2 * HALF_W;

  logic [SW-1:0] work_q, work_d;
  ctrl_t         ctrl_q, ctrl_d;

  always_comb begin
    work_d = work_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (sel_e'(wr_sel))
        SEL_LO:   work_d[HALF_W-1:0]  = wr_data;
        SEL_HI:   work_d[SW-1:HALF_W] = wr_data;
        SEL_CTRL: ctrl_d = '{en: wr_data[0], inv: wr_data[1], lvl: wr_data[2]};
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      ctrl_q <= '0;
    end else begin
      work_q <= work_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign work = work_q;
  assign ctrl = ctrl_q;

  // R8: only a control-select write may alter the control word
  assert_ctrl_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd2) |=> $stable(ctrl_q));
  // R6: a low-half write leaves the high half untouched
  assert_half_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> $stable(work_q[SW-1:HALF_W]));
endmodule

// File: rtl/cfp_gen.sv
module cfp_gen
  import cfp_pkg::*;
#(
  parameter int HALF_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [2*HALF_W-1:0] work,
  input  ctrl_t               ctrl,
  output logic                pwm_o
);
  localparam int CW = 2 * HALF_W;

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     act_q, act_d;
  logic [HALF_W-1:0] pos, sub, act_lo, act_hi, pick;
  logic              coarse, fine, raw;

  assign pos    = cnt_q[HALF_W-1:0];
  assign sub    = cnt_q[CW-1:HALF_W];
  assign act_lo = act_q[HALF_W-1:0];
  assign act_hi = act_q[CW-1:HALF_W];

  // one-hot trailing-zero decode of the subperiod index, gated by cleared low bits
  for (genvar k = 0; k < HALF_W; k++) begin : g_pick
    if (k == 0) begin : g_first
      assign pick[k] = sub[0] & ~act_lo[0];
    end else begin : g_rest
      assign pick[k] = sub[k] & ~(|sub[k-1:0]) & ~act_lo[k];
    end
  end

  always_comb begin
    cnt_d = tick ? cnt_q + 1'b1 : cnt_q;
    act_d = (tick && (&pos)) ? work : act_q;
    coarse = (pos > act_hi);
    fine   = (pos == '0) && (|pick);
    raw    = coarse | fine;
    pwm_o  = ctrl.en ? (raw ^ ctrl.inv) : ctrl.lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R2: counter holds between ticks
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R2: counter steps by one on a tick, wrapping
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == CW'($past(cnt_q) + 1'b1));
  // R6: the working copy changes only as a new subperiod begins
  assert_load_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> pos == '0);
  // R4: fine pulses sit at position 0 of a nonzero subperiod
  assert_fine_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fine |-> (pos == '0 && sub != '0));
  // R3: coarse pulse is low at the start of every subperiod
  assert_coarse_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0) |-> !coarse);
endmodule

// File: rtl/cfpwm14.sv
module cfpwm14
  import cfp_pkg::*;
#(
  parameter int HALF_W = 7,
  parameter int DIV    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  output logic              pwm_o
);
  localparam int SW = 2 * HALF_W;

  logic          rst_sync_n;
  logic          tick;
  logic [SW-1:0] work;
  ctrl_t         ctrl;

  cfp_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfp_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  cfp_regs #(.HALF_W(HALF_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .work    (work),
    .ctrl    (ctrl)
  );

  cfp_gen #(.HALF_W(HALF_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick),
    .work  (work),
    .ctrl  (ctrl),
    .pwm_o (pwm_o)
  );

  // R1: output is low while held in reset
  assert_reset_low_R1: assert property (@(posedge clk) !rst_sync_n |-> !pwm_o);
endmodule

// File: tb/cfpwm14_test.sv
`timescale 1ns/1ps
module cfpwm14_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [6:0] wr_data = 7'd0;
  logic       pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cfpwm14 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  // behavioural reference
  int m_sync = 0, m_div = 0, m_cnt = 0;
  int m_hi = 0, m_lo = 0, a_hi = 0, a_lo = 0;
  int m_en = 0, m_inv = 0, m_lvl = 0;

  function automatic int fine_hit(int s, int lo);
    int k;
    if (s == 0) return 0;
    k = 0;
    while (((s >> k) & 1) == 0) k++;
    return (((lo >> k) & 1) == 0) ? 1 : 0;
  endfunction

  function automatic int model_out();
    int p, s, r;
    p = m_cnt % 128;
    s = m_cnt / 128;
    r = ((p > a_hi) || (p == 0 && fine_hit(s, a_lo) != 0)) ? 1 : 0;
    if (m_en == 0) return m_lvl;
    return r ^ m_inv;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_div = 0; m_cnt = 0;
      m_hi = 0; m_lo = 0; a_hi = 0; a_lo = 0;
      m_en = 0; m_inv = 0; m_lvl = 0;
    end else begin
      if (m_sync >= 2) begin
        if (m_div == 2) begin
          m_div = 0;
          if (m_cnt % 128 == 127) begin a_hi = m_hi; a_lo = m_lo; end
          m_cnt = (m_cnt + 1) % 16384;
        end else m_div = m_div + 1;
        if (wr_en) begin
          case (wr_sel)
            2'd0: m_lo = int'(wr_data);
            2'd1: m_hi = int'(wr_data);
            2'd2: begin m_en = wr_data[0]; m_inv = wr_data[1]; m_lvl = wr_data[2]; end
            default: ;
          endcase
        end
      end
      if (m_sync < 2) m_sync = m_sync + 1;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(pwm_o) != model_out()) begin
        errors++;
        $display("FAIL %s cycle compare: actual %0d expected %0d", cur_req, pwm_o, model_out());
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 7'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(int n, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_o) hits++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    int h;
    repeat (4) @(negedge clk);
    check("R1", int'(pwm_o), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", int'(pwm_o), 0);

    cur_req = "R8";
    wr(3, 7'h7F);                  // ignored select
    count_high(20, h); check("R8", h, 0);

    wr(0, 7'h7F); wr(1, 10); wr(2, 1);
    cur_req = "R3";
    repeat (800) @(negedge clk);
    count_high(384, h); check("R3", h, 3 * (127 - 10));

    cur_req = "R2";
    wr(1, 0);
    repeat (800) @(negedge clk);
    count_high(384, h); check("R2", h, 381);

    cur_req = "R3";
    wr(1, 127);
    repeat (800) @(negedge clk);
    count_high(384, h); check("R3", h, 0);

    cur_req = "R7";
    wr(1, 10); wr(2, 3);
    repeat (800) @(negedge clk);
    count_high(384, h); check("R7", h, 384 - 351);

    cur_req = "R8";
    wr(2, 0); count_high(50, h); check("R8", h, 0);
    wr(2, 4); count_high(50, h); check("R8", h, 50);
    wr(2, 1);

    cur_req = "R6";
    repeat (190) @(negedge clk);
    wr(1, 60);                     // mid-subperiod update
    repeat (900) @(negedge clk);
    count_high(384, h); check("R6", h, 3 * (127 - 60));

    cur_req = "R4";
    wr(1, 127); wr(0, 7'h7A);      // bits 0 and 2 clear: 64 + 16 subperiods
    repeat (400) @(negedge clk);
    count_high(49152, h); check("R4", h, 3 * 80);

    cur_req = "R5";
    wr(1, 100); wr(0, 7'h3E);      // bits 0 and 6 clear: 64 + 1 subperiods
    repeat (400) @(negedge clk);
    count_high(49152, h); check("R5", h, 3 * (128 * 27 + 65));

    cur_req = "R9";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check("R9", int'(pwm_o), 0);
    rst_n = 1'b1;
    count_high(60, h); check("R9", h, 0);
    wr(2, 1);                      // latch cleared: hi 0, lo 0
    repeat (2000) @(negedge clk);
    finish_run();
  end
endmodule